// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives a two-channel serial audio stream as a slave. The bit clock, the frame clock and the serial data line come from the outside. All three are brought into the system clock domain through a short synchronizer. A rising bit-clock edge is detected by oversampling, and each such edge contributes one data bit. A change of the frame clock's level marks the start of a new half-frame, and the bit position is counted from that change.

A 3-bit format select picks one of five alignments: LSB-justified at 16, 20 or 24 bits, 20-bit MSB-justified, or I2S. The receiver extracts each channel's word and places it at the top of a 24-bit two's complement output, with zeros in the bits below the word. Once the right channel of a frame is complete, it presents the left and right words together with a one-cycle valid strobe.

Top module: `sar_rx`

## Requirements
- R1: While `rst` is high, and from the cycle after it is sampled high, `left_out` and `right_out` read zero and `pair_valid` is low. A reset in the middle of a stream clears any pair already presented.
- R2: Format code 000 (16-bit LSB-justified): the word is the 16 bits in the last 16 bit slots before a frame-clock transition, and the earlier slots in that half are ignored.
- R3: Format code 001 (20-bit LSB-justified): the word is the 20 bits in the last 20 slots before a frame-clock transition, and the earlier slots are ignored.
- R4: Format code 100 (24-bit LSB-justified): the word is the 24 bits in the last 24 slots before a frame-clock transition, and the earlier slots are ignored.
- R5: Format code 010 (20-bit MSB-justified): the MSB sits in the first slot after a frame-clock transition, followed by the next 19 bits, and later slots are ignored.
- R6: Format code 011 (I2S): the MSB sits in the second slot after a transition, and the left channel is the half in which the frame clock is low. The word is 20 bits when the half is longer than 20 slots. With 16 slots per half the word is 16 bits, and its LSB falls in the first slot of the following half.
- R7: In the three LSB-justified codes and the MSB-justified code, the half with the frame clock high is the left channel and the half with it low is the right channel.
- R8: A word of N bits (N < 24) occupies bits 23 down to 24-N of its output, and bits 23-N down to 0 read zero. Data are two's complement and sent MSB first.
- R9: `pair_valid` pulses for exactly one system-clock cycle after each complete right half that follows a complete left half. Whatever half is in progress when reset is released produces nothing.
- R10: Format codes 101, 110 and 111 are unused. With them, `pair_valid` never rises and both outputs keep their reset value of zero.
- R11: Data and frame clock are sampled only on bit-clock rising edges, one bit per edge. Decoding is the same for any half-frame length from the word length up to 32 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| fclk_in | input | 1 | Frame clock, left/right select (asynchronous) |
| sdata_in | input | 1 | Serial data, MSB first (asynchronous) |
| fmt_sel | input | 3 | Format select, codes 000..100 valid |
| left_out | output | 24 | Left-channel word, MSB-aligned |
| right_out | output | 24 | Right-channel word, MSB-aligned |
| pair_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
Every legal format runs at its shortest half-frame and at 32 slots per half. The shortest half checks that each word boundary is counted exactly. The 32-slot half fills the unused slots with random bits, so a design that takes bits from the wrong end of a half, or from a slot that should be ignored, gives a wrong word. Each stream starts with a lone half-frame and ends with a trailing one. This exposes a strobe from the partial first half and a lost last pair. The word values include the most negative value, all ones, a lone LSB and zero, so that bit order, sign position and zero fill can each be told apart. The I2S run with 16 slots per half checks that the LSB is taken from the first slot of the next half.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int OUT_W  = 24;
    localparam int LEN_W  = 5;
    localparam int FMT_W  = 3;
    localparam int SLOT_W = 6;

    localparam logic [FMT_W-1:0] FMT_LSB16 = 3'b000;
    localparam logic [FMT_W-1:0] FMT_LSB20 = 3'b001;
    localparam logic [FMT_W-1:0] FMT_MSB20 = 3'b010;
    localparam logic [FMT_W-1:0] FMT_I2S   = 3'b011;
    localparam logic [FMT_W-1:0] FMT_LSB24 = 3'b100;

    typedef struct packed {
        logic             legal;
        logic             lsb_just;
        logic             i2s;
        logic [LEN_W-1:0] wlen;
    } fmt_info_t;

    typedef struct packed {
        logic              valid;
        logic              data;
        logic              boundary;
        logic              ended_lvl;
        logic [SLOT_W-1:0] slot;
    } bit_ev_t;

    typedef struct packed {
        logic             valid;
        logic             ended_lvl;
        logic [OUT_W-1:0] data;
        logic [LEN_W-1:0] nbits;
    } word_ev_t;

    function automatic fmt_info_t decode_fmt(input logic [FMT_W-1:0] code);
        fmt_info_t f;
        f.legal    = 1'b1;
        f.lsb_just = 1'b0;
        f.i2s      = 1'b0;
        f.wlen     = LEN_W'(20);
        case (code)
            FMT_LSB16: begin f.lsb_just = 1'b1; f.wlen = LEN_W'(16); end
            FMT_LSB20: begin f.lsb_just = 1'b1; end
            FMT_MSB20: begin end
            FMT_I2S:   begin f.i2s = 1'b1; end
            FMT_LSB24: begin f.lsb_just = 1'b1; f.wlen = LEN_W'(OUT_W); end
            default:   begin f.legal = 1'b0; f.lsb_just = 1'b1; f.wlen = LEN_W'(OUT_W); end
        endcase
        return f;
    endfunction

    function automatic logic [OUT_W-1:0] left_align(input logic [OUT_W-1:0] raw,
                                                    input logic [LEN_W-1:0] nb);
        logic [OUT_W:0] m;
        m = ((OUT_W+1)'(1) << nb) - (OUT_W+1)'(1);
        return (raw & m[OUT_W-1:0]) << (OUT_W - int'(nb));
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sar_bit_tracker.sv
module sar_bit_tracker
    import sar_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bclk_s,
    input  logic    fclk_s,
    input  logic    sdata_s,
    output bit_ev_t ev
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    logic              bclk_q;
    logic              primed;
    logic              lvl_q;
    logic [SLOT_W-1:0] slot_q;
    logic              rise;
    logic              flip;

    assign rise = bclk_s & ~bclk_q;
    assign flip = primed & (fclk_s != lvl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            primed <= 1'b0;
            lvl_q  <= 1'b0;
            slot_q <= '0;
            ev     <= '0;
        end else begin
            bclk_q   <= bclk_s;
            ev.valid <= 1'b0;
            if (rise) begin
                ev.valid     <= primed;
                ev.data      <= sdata_s;
                ev.boundary  <= flip;
                ev.ended_lvl <= lvl_q;
                ev.slot      <= flip ? '0 : slot_q;
                primed       <= 1'b1;
                lvl_q        <= fclk_s;
                if (flip)                  slot_q <= SLOT_W'(1);
                else if (slot_q != SLOT_MAX) slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    AST_ONE_BIT_PER_RISE: assert property (@(posedge clk) disable iff (rst)
        ev.valid |=> !ev.valid); // R11

endmodule

// File: rtl/sar_word_capture.sv
module sar_word_capture
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bit_ev_t          ev,
    input  logic             lsb_just,
    input  logic             i2s,
    input  logic [LEN_W-1:0] wlen,
    output word_ev_t         wev
);
    logic [OUT_W-1:0] shreg;
    logic [OUT_W-1:0] cap;
    logic [LEN_W-1:0] capcnt;
    logic [OUT_W-1:0] fin_raw;
    logic [LEN_W-1:0] fin_nb;
    logic             take;
    logic [OUT_W-1:0] tail_mask;

    assign take = (ev.slot >= (i2s ? SLOT_W'(1) : SLOT_W'(0))) && (capcnt < wlen);

    always_comb begin
        if (lsb_just) begin
            fin_raw = shreg;
            fin_nb  = wlen;
        end else if (i2s && (capcnt < wlen)) begin
            fin_raw = {cap[OUT_W-2:0], ev.data};
            fin_nb  = capcnt + LEN_W'(1);
        end else begin
            fin_raw = cap;
            fin_nb  = capcnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            cap    <= '0;
            capcnt <= '0;
            wev    <= '0;
        end else begin
            wev.valid <= 1'b0;
            if (ev.valid) begin
                shreg <= {shreg[OUT_W-2:0], ev.data};
                if (ev.boundary) begin
                    wev.valid     <= 1'b1;
                    wev.ended_lvl <= ev.ended_lvl;
                    wev.data      <= left_align(fin_raw, fin_nb);
                    wev.nbits     <= fin_nb;
                    if (!lsb_just && !i2s) begin
                        cap    <= {{(OUT_W-1){1'b0}}, ev.data};
                        capcnt <= LEN_W'(1);
                    end else begin
                        cap    <= '0;
                        capcnt <= '0;
                    end
                end else if (take) begin
                    cap    <= {cap[OUT_W-2:0], ev.data};
                    capcnt <= capcnt + LEN_W'(1);
                end
            end
        end
    end

    assign tail_mask = ~({OUT_W{1'b1}} << (OUT_W - int'(wev.nbits)));

    AST_CAPCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        capcnt <= wlen); // R5
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        wev.valid |-> ((wev.data & tail_mask) == '0)); // R8

endmodule

// File: rtl/sar_pair_out.sv
module sar_pair_out
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  word_ev_t         wev,
    input  logic             i2s,
    input  logic             legal,
    output logic [OUT_W-1:0] left_out,
    output logic [OUT_W-1:0] right_out,
    output logic             pair_valid
);
    logic             seen;
    logic             have_left;
    logic [OUT_W-1:0] left_hold;
    logic             valid_q;
    logic             is_left;

    assign is_left    = wev.ended_lvl ^ i2s;
    assign pair_valid = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen      <= 1'b0;
            have_left <= 1'b0;
            left_hold <= '0;
            left_out  <= '0;
            right_out <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (wev.valid) begin
                if (!seen) begin
                    seen <= 1'b1;
                end else if (is_left) begin
                    left_hold <= wev.data;
                    have_left <= 1'b1;
                end else begin
                    have_left <= 1'b0;
                    if (have_left && legal) begin
                        left_out  <= left_hold;
                        right_out <= wev.data;
                        valid_q   <= 1'b1;
                    end
                end
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!valid_q && left_out == '0 && right_out == '0)); // R1
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R9
    AST_STROBE_NEEDS_LEFT: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(have_left)); // R9
    AST_ILLEGAL_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (wev.valid && !legal) |=> !valid_q); // R10

endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_in,
    input  logic             fclk_in,
    input  logic             sdata_in,
    input  logic [FMT_W-1:0] fmt_sel,
    output logic [OUT_W-1:0] left_out,
    output logic [OUT_W-1:0] right_out,
    output logic             pair_valid
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    fmt_info_t        info;
    bit_ev_t          ev;
    word_ev_t         wev;

    assign info = decode_fmt(fmt_sel);

    sar_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_W)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sdata_in, fclk_in, bclk_in}),
        .dout (pins_s)
    );

    sar_bit_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .bclk_s  (pins_s[0]),
        .fclk_s  (pins_s[1]),
        .sdata_s (pins_s[2]),
        .ev      (ev)
    );

    sar_word_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .lsb_just (info.lsb_just),
        .i2s      (info.i2s),
        .wlen     (info.wlen),
        .wev      (wev)
    );

    sar_pair_out u_pair (
        .clk        (clk),
        .rst        (rst),
        .wev        (wev),
        .i2s        (info.i2s),
        .legal      (info.legal),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

endmodule

// File: tb/sar_rx_tb_top.sv
module sar_rx_tb_top;
    localparam int F = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        pair_valid;

    int          n_chk = 0;
    int          n_bad = 0;
    int          got_n = 0;
    int          cur_n = 16;
    string       cur_req = "R2";
    logic [23:0] exp_l [0:F-1];
    logic [23:0] exp_r [0:F-1];
    logic        st_d  [0:511];
    logic        st_l  [0:511];

    always #2 clk = ~clk;

    sar_rx dut_i (
        .clk        (clk),
        .rst        (rst),
        .bclk_in    (bclk),
        .fclk_in    (fclk),
        .sdata_in   (sdata),
        .fmt_sel    (fmt),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && pair_valid) begin
            if (got_n < F) begin
                logic [23:0] tmask;
                tmask = ~(24'hFFFFFF << (24 - cur_n));
                check(cur_req, left_out, exp_l[got_n]);
                check({cur_req, " R7"}, right_out, exp_r[got_n]);
                check("R8", left_out & tmask, 24'h0);
                check("R8", right_out & tmask, 24'h0);
            end
            got_n++;
        end
    end

    task automatic put_word(input int start, input int h, input logic [2:0] f,
                            input int n, input logic [23:0] v);
        for (int i = 0; i < n; i++) begin
            int s;
            if (f == 3'b010)      s = start + i;
            else if (f == 3'b011) s = start + 1 + i;
            else                  s = start + h - n + i;
            st_d[s] = v[n-1-i];
        end
    endtask

    task automatic drive_slot(input logic l, input logic d);
        @(posedge clk); #1;
        fclk = l; sdata = d; bclk = 1'b0;
        repeat (4) @(posedge clk);
        #1 bclk = 1'b1;
        repeat (4) @(posedge clk);
        #1 bclk = 1'b0;
    endtask

    task automatic run_cfg(input logic [2:0] f, input int h, input string req);
        int          halves;
        logic        left_lvl;
        logic        legal;
        logic [23:0] m;
        legal = (f <= 3'b100);
        @(posedge clk); #1;
        rst = 1'b1; fmt = f; bclk = 1'b0; fclk = 1'b0; sdata = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", left_out, 24'h0);
        check("R1", right_out, 24'h0);
        check("R1", {23'h0, pair_valid}, 24'h0);
        case (f)
            3'b000:  cur_n = 16;
            3'b001:  cur_n = 20;
            3'b010:  cur_n = 20;
            3'b011:  cur_n = (h < 20) ? 16 : 20;
            default: cur_n = 24;
        endcase
        cur_req = req;
        got_n = 0;
        halves = 2 * F + 2;
        left_lvl = (f == 3'b011) ? 1'b0 : 1'b1;
        m = 24'hFFFFFF >> (24 - cur_n);
        for (int s = 0; s < halves * h; s++) begin
            st_d[s] = 1'($urandom);
            st_l[s] = ((s / h) % 2 == 1) ? left_lvl : ~left_lvl;
        end
        for (int k = 0; k < F; k++) begin
            logic [23:0] lv, rv;
            if (k == 0)      begin lv = 24'h1 << (cur_n - 1); rv = 24'h1; end
            else if (k == 1) begin lv = m; rv = 24'h0; end
            else begin
                lv = (24'(k) * 24'h05A3C7 + 24'(h) * 24'h001111 + 24'(f)) & m;
                rv = (~lv ^ (24'(k) << 3)) & m;
            end
            exp_l[k] = lv << (24 - cur_n);
            exp_r[k] = rv << (24 - cur_n);
            put_word((2 * k + 1) * h, h, f, cur_n, lv);
            put_word((2 * k + 2) * h, h, f, cur_n, rv);
        end
        @(posedge clk); #1 rst = 1'b0;
        for (int s = 0; s < halves * h; s++) drive_slot(st_l[s], st_d[s]);
        repeat (40) @(posedge clk);
        @(negedge clk);
        if (legal) begin
            check({req, " R9 R11"}, 24'(got_n), 24'(F));
        end else begin
            check("R10", 24'(got_n), 24'h0);
            check("R10", left_out, 24'h0);
            check("R10", right_out, 24'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        run_cfg(3'b000, 16, "R2");
        run_cfg(3'b000, 32, "R2");
        run_cfg(3'b001, 20, "R3");
        run_cfg(3'b001, 32, "R3");
        run_cfg(3'b100, 24, "R4");
        run_cfg(3'b100, 32, "R4");
        run_cfg(3'b010, 20, "R5");
        run_cfg(3'b010, 32, "R5");
        run_cfg(3'b011, 32, "R6");
        run_cfg(3'b011, 16, "R6");
        run_cfg(3'b101, 32, "R10");
        run_cfg(3'b111, 24, "R10");
        run_cfg(3'b000, 24, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule